// File: doc/BRIEF.md
# Instruction Field Length Calculator

This block is used in a variable-length instruction front end, after the prefixes and the opcode have been resolved. It takes a 10-bit opcode index, the byte position of the opcode inside the instruction, the effective operand and address sizes, a 64-bit mode flag, and the two bytes that follow the opcode. From these it works out where the trailing fields of the instruction sit: the addressing byte, the optional scale/index/base byte, the displacement, and the immediate. It then adds them up to give the total instruction length. Prefix scanning and the meaning of the operation are handled elsewhere.

Three per-opcode bit tables say what each opcode carries. One marks opcodes followed by an addressing byte. One marks opcodes with an immediate. One marks opcodes whose immediate is a single sign-extended byte rather than an operand-sized value. The tables are cleared by reset and filled through a one-bit write port.

Everything after the tables is combinational, so the field layout for the presented opcode is valid in the same cycle. A flag marks instruction-pointer-relative addressing. An error flag is raised when the length is too long for the architecture or for the bytes on hand.

Top module: `oplen_fields`

## Requirements
- R1: Reset clears all three tables. When `tbl_we` is high, a rising clock edge writes `tbl_val` at index `tbl_idx` of the table picked by `tbl_sel`: 0 is the addressing-byte table, 1 is the immediate-present table, 2 is the byte-immediate table. A write with `tbl_sel`=3 changes no table.
- R2: `has_modrm` equals the addressing-byte table bit at `op_idx`. When that bit is 0, there is no scale/index/base byte and no displacement.
- R3: The addressing byte is `follow[7:0]`, with mod in bits 7:6 and rm in bits 2:0. The scale/index/base byte is `follow[15:8]`, with its base field in bits 2:0. `has_sib` is set when an addressing byte is present, the address size is not 16-bit (`adr_sz` 0), mod≠3 and rm=4. It is never set for 16-bit addressing.
- R4: For 32/64-bit addressing (`adr_sz` 1, 2 or 3), the displacement length is decided by mod. For mod=3 it is 0. For mod=1 it is 1. For mod=2 it is 4. For mod=0 it is 4 when rm=5, or when a scale/index/base byte is present and its base field is 5. Any other mod=0 case gives 0.
- R5: For 16-bit addressing, the displacement length is 2 for mod=0 with rm=6, 0 for any other mod=0 case, 1 for mod=1, 2 for mod=2 and 0 for mod=3.
- R6: `rip_rel` is set only when all of these hold: an addressing byte is present, `mode64` is 1, the address size is not 16-bit, mod=0 and rm=5.
- R7: When the immediate-present bit is 0, `imm_len` is 0. Otherwise, if the byte-immediate bit is set, `imm_len` is 1. If it is not set, `imm_len` follows the operand size `op_sz` (0=8, 1=16, 2=32, 3=64 bits): 1, 2, 4 and 4 bytes, since a 64-bit operand takes a 4-byte sign-extended immediate.
- R8: The opcode at index `ACC_IDX` with an immediate present and `op_sz`=3 takes an 8-byte immediate. This overrides R7.
- R9: `disp_off` is `op_off`+1+`has_modrm`+`has_sib`. `imm_off` is `disp_off`+`disp_len`. `ins_len` is `imm_off`+`imm_len`.
- R10: `len_err` is set exactly when `ins_len` exceeds 15 or exceeds `avail`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for table writes |
| rst_n | input | 1 | Active-low reset, clears the tables |
| tbl_we | input | 1 | Table write enable |
| tbl_sel | input | 2 | Table select for the write |
| tbl_idx | input | 10 | Table index for the write |
| tbl_val | input | 1 | Bit value to write |
| op_idx | input | 10 | Resolved opcode index |
| op_off | input | 4 | Byte position of the opcode within the instruction |
| op_sz | input | 2 | Effective operand size code |
| adr_sz | input | 2 | Effective address size code (0=16, 1=32, 2/3=64) |
| mode64 | input | 1 | 64-bit execution mode |
| follow | input | 16 | The two bytes after the opcode |
| avail | input | 5 | Number of valid instruction bytes on hand |
| has_modrm | output | 1 | Addressing byte present |
| has_sib | output | 1 | Scale/index/base byte present |
| disp_off | output | 6 | Displacement byte offset |
| disp_len | output | 3 | Displacement length in bytes |
| imm_off | output | 6 | Immediate byte offset |
| imm_len | output | 4 | Immediate length in bytes |
| ins_len | output | 6 | Total instruction length in bytes |
| rip_rel | output | 1 | Instruction-pointer-relative addressing |
| len_err | output | 1 | Length over 15 or over `avail` |

## Verification
Some rules are checked by the assertions on every cycle. A scale/index/base byte only ever appears with an addressing byte and never in 16-bit addressing. The immediate always closes the instruction, and the length adds up. The error flag agrees with both length limits. The instruction-pointer-relative flag comes only with 64-bit mode and a 4-byte displacement. A table write lands at the written index. The exact displacement and immediate sizes for each mod/rm/base pattern, and the accumulator override, can only be shown by the bench sweep. The same holds for the reset contents of the tables and for writes with the spare select having no effect. The sweep runs every addressing-byte value against the base-field values, the address and operand sizes, the mode flag and several table settings.

// File: rtl/oplen_fields.sv
module oplen_fields #(
  parameter int IDX_W = 10,
  parameter logic [IDX_W-1:0] ACC_IDX = IDX_W'('h0B8),
  parameter int LEN_MAX = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tbl_we,
  input  logic [1:0]       tbl_sel,
  input  logic [IDX_W-1:0] tbl_idx,
  input  logic             tbl_val,
  input  logic [IDX_W-1:0] op_idx,
  input  logic [3:0]       op_off,
  input  logic [1:0]       op_sz,
  input  logic [1:0]       adr_sz,
  input  logic             mode64,
  input  logic [15:0]      follow,
  input  logic [4:0]       avail,
  output logic             has_modrm,
  output logic             has_sib,
  output logic [5:0]       disp_off,
  output logic [2:0]       disp_len,
  output logic [5:0]       imm_off,
  output logic [3:0]       imm_len,
  output logic [5:0]       ins_len,
  output logic             rip_rel,
  output logic             len_err
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0] mrm_tbl, imm_tbl, ib_tbl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mrm_tbl <= '0;
      imm_tbl <= '0;
      ib_tbl  <= '0;
    end else if (tbl_we) begin
      case (tbl_sel)
        2'd0:    mrm_tbl[tbl_idx] <= tbl_val;
        2'd1:    imm_tbl[tbl_idx] <= tbl_val;
        2'd2:    ib_tbl[tbl_idx]  <= tbl_val;
        default: ;
      endcase
    end
  end

  logic [1:0] md;
  logic [2:0] rm, sbase;
  logic       a16, imm_on;
  logic       unused_bits;

  assign md     = follow[7:6];
  assign rm     = follow[2:0];
  assign sbase  = follow[10:8];
  assign a16    = (adr_sz == 2'd0);
  assign imm_on = imm_tbl[op_idx];
  assign unused_bits = ^{follow[5:3], follow[15:11]};

  assign has_modrm = mrm_tbl[op_idx];
  assign has_sib   = has_modrm && !a16 && (md != 2'd3) && (rm == 3'd4);
  assign rip_rel   = has_modrm && !a16 && mode64 && (md == 2'd0) && (rm == 3'd5);

  always_comb begin
    disp_len = 3'd0;
    if (has_modrm) begin
      if (a16) begin
        case (md)
          2'd0:    disp_len = (rm == 3'd6) ? 3'd2 : 3'd0;
          2'd1:    disp_len = 3'd1;
          2'd2:    disp_len = 3'd2;
          default: disp_len = 3'd0;
        endcase
      end else begin
        case (md)
          2'd0:    disp_len = ((rm == 3'd5) || (has_sib && sbase == 3'd5)) ? 3'd4 : 3'd0;
          2'd1:    disp_len = 3'd1;
          2'd2:    disp_len = 3'd4;
          default: disp_len = 3'd0;
        endcase
      end
    end
  end

  always_comb begin
    if (!imm_on)                                   imm_len = 4'd0;
    else if (op_idx == ACC_IDX && op_sz == 2'd3)   imm_len = 4'd8;
    else if (ib_tbl[op_idx])                       imm_len = 4'd1;
    else begin
      case (op_sz)
        2'd0:    imm_len = 4'd1;
        2'd1:    imm_len = 4'd2;
        default: imm_len = 4'd4;
      endcase
    end
  end

  assign disp_off = {2'b0, op_off} + 6'd1 + {5'b0, has_modrm} + {5'b0, has_sib};
  assign imm_off  = disp_off + {3'b0, disp_len};
  assign ins_len  = imm_off + {2'b0, imm_len};
  assign len_err  = (ins_len > 6'(LEN_MAX)) || (ins_len > {1'b0, avail});

  // R1
  tbl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tbl_we && tbl_sel == 2'd0) |=> (mrm_tbl[$past(tbl_idx)] == $past(tbl_val)));

  // R3
  sib_needs_mrm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    has_sib |-> (has_modrm && adr_sz != 2'd0));

  // R6
  rip_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rip_rel |-> (mode64 && disp_len == 3'd4 && !has_sib));

  // R9
  imm_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_len == imm_off + {2'b0, imm_len}) && (imm_off >= disp_off + {3'b0, disp_len}));

  // R10
  len_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !len_err |-> (ins_len <= 6'(LEN_MAX) && ins_len <= {1'b0, avail}));

  // R2
  no_mrm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !has_modrm |-> (disp_len == 3'd0 && !has_sib && !rip_rel));
endmodule

// File: tb/sim_oplen_fields.sv
module sim_oplen_fields;
  logic clk = 0, rst_n = 0;
  logic tbl_we = 0, tbl_val = 0;
  logic [1:0] tbl_sel = 0;
  logic [9:0] tbl_idx = 0, op_idx = 0;
  logic [3:0] op_off = 0;
  logic [1:0] op_sz = 0, adr_sz = 0;
  logic mode64 = 0;
  logic [15:0] follow = 0;
  logic [4:0] avail = 15;
  logic has_modrm, has_sib, rip_rel, len_err;
  logic [5:0] disp_off, imm_off, ins_len;
  logic [2:0] disp_len;
  logic [3:0] imm_len;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  oplen_fields u0 (.clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_sel(tbl_sel),
    .tbl_idx(tbl_idx), .tbl_val(tbl_val), .op_idx(op_idx), .op_off(op_off),
    .op_sz(op_sz), .adr_sz(adr_sz), .mode64(mode64), .follow(follow), .avail(avail),
    .has_modrm(has_modrm), .has_sib(has_sib), .disp_off(disp_off), .disp_len(disp_len),
    .imm_off(imm_off), .imm_len(imm_len), .ins_len(ins_len), .rip_rel(rip_rel),
    .len_err(len_err));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      if (fails < 20) $display("FAIL %s op=%h mrm=%h sib=%h adr=%0d osz=%0d: actual %0d expected %0d",
                               req, op_idx, follow[7:0], follow[15:8], adr_sz, op_sz, act, exp);
    end
  endtask

  task automatic twr(input int sel, input int idx, input bit v);
    @(negedge clk);
    tbl_we = 1; tbl_sel = 2'(sel); tbl_idx = 10'(idx); tbl_val = v;
    @(negedge clk);
    tbl_we = 0;
  endtask

  // bench-side knowledge of the table contents
  bit m_m[int], m_i[int], m_b[int];

  task automatic expect_all(input int off);
    int md, rm, sb, mrm, sib, dl, il, d_off, i_off, len, rip;
    md = follow[7:6]; rm = follow[2:0]; sb = follow[10:8];
    mrm = m_m.exists(int'(op_idx)) ? int'(m_m[int'(op_idx)]) : 0;
    sib = 0; dl = 0; rip = 0;
    if (mrm == 1 && md != 3) begin
      if (adr_sz == 0) begin
        if (md == 1) dl = 1; else if (md == 2) dl = 2; else if (rm == 6) dl = 2;
      end else begin
        if (rm == 4) sib = 1;
        if (md == 1) dl = 1;
        else if (md == 2) dl = 4;
        else if (rm == 5) begin dl = 4; rip = mode64 ? 1 : 0; end
        else if (sib == 1 && sb == 5) dl = 4;
      end
    end
    il = 0;
    if (m_i.exists(int'(op_idx)) && m_i[int'(op_idx)]) begin
      if (op_idx == 10'h0B8 && op_sz == 3) il = 8;
      else if (m_b.exists(int'(op_idx)) && m_b[int'(op_idx)]) il = 1;
      else il = (op_sz == 0) ? 1 : (op_sz == 1) ? 2 : 4;
    end
    d_off = off + 1 + mrm + sib;
    i_off = d_off + dl;
    len = i_off + il;
    chk("R2", int'(has_modrm), mrm);
    chk("R3", int'(has_sib), sib);
    chk(adr_sz == 0 ? "R5" : "R4", int'(disp_len), dl);
    chk("R6", int'(rip_rel), rip);
    chk(op_idx == 10'h0B8 ? "R8" : "R7", int'(imm_len), il);
    chk("R9", int'(disp_off), d_off);
    chk("R9", int'(imm_off), i_off);
    chk("R9", int'(ins_len), len);
    chk("R10", int'(len_err), (len > 15 || len > int'(avail)) ? 1 : 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int ids[6] = '{'h010, 'h020, 'h030, 'h040, 'h0B8, 'h300};
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: tables empty after reset
    op_idx = 10'h040; op_off = 2; follow = 16'h0484; #1;
    chk("R1", int'(has_modrm), 0);
    chk("R1", int'(imm_len), 0);
    chk("R1", int'(ins_len), 3);

    twr(0, 'h010, 1); m_m['h010] = 1;
    twr(1, 'h020, 1); m_i['h020] = 1;
    twr(0, 'h030, 1); m_m['h030] = 1;
    twr(1, 'h030, 1); m_i['h030] = 1;
    twr(2, 'h030, 1); m_b['h030] = 1;
    twr(0, 'h040, 1); m_m['h040] = 1;
    twr(1, 'h040, 1); m_i['h040] = 1;
    twr(1, 'h0B8, 1); m_i['h0B8] = 1;
    twr(0, 'h300, 1); m_m['h300] = 1;
    // R1: select 3 writes nothing
    twr(3, 'h050, 1);
    op_idx = 10'h050; op_off = 1; follow = 16'h0080; #1;
    chk("R1", int'(has_modrm), 0);
    chk("R1", int'(imm_len), 0);
    chk("R1", int'(ins_len), 2);

    // R10 boundaries: opcode at 4, mod=2 rm=4 sib, disp32, imm32 => 15
    op_idx = 10'h040; op_off = 4; op_sz = 2; adr_sz = 1; follow = 16'h0084; avail = 15; #1;
    chk("R10", int'(ins_len), 15);
    chk("R10", int'(len_err), 0);
    avail = 14; #1;
    chk("R10", int'(len_err), 1);
    op_off = 5; avail = 31; #1;
    chk("R10", int'(ins_len), 16);
    chk("R10", int'(len_err), 1);

    // sweep all addressing bytes, base fields, sizes and modes
    @(negedge clk);
    foreach (ids[k]) begin
      for (int osz = 0; osz < 4; osz++)
        for (int asz = 0; asz < 3; asz++)
          for (int m64 = 0; m64 < 2; m64++)
            for (int mb = 0; mb < 256; mb++)
              for (int b = 0; b < 8; b++) begin
                op_idx = 10'(ids[k]); op_sz = 2'(osz); adr_sz = 2'(asz); mode64 = m64[0];
                op_off = 4'((mb + b) & 7);
                avail = 5'(8 + ((mb ^ b) & 15));
                follow = {2'(b & 3), 3'(7 - b), 3'(b), 8'(mb)};
                #1;
                expect_all((mb + b) & 7);
              end
    end

    // R1: clearing a bit through the port
    twr(0, 'h300, 0); m_m['h300] = 0;
    op_idx = 10'h300; op_off = 0; adr_sz = 1; follow = 16'h0044; #1;
    chk("R1", int'(has_modrm), 0);
    chk("R2", int'(disp_len), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule